// File: doc/BRIEF.md
# Three-Bank Masked Interrupt Controller

The block gathers 96 level-sensitive interrupt lines into three 32-bit banks: bank 0 holds flat indices 0 to 31, bank 1 holds 32 to 63 and bank 2 holds 64 to 95. Each bank has a sampled status word and a mask word. A line takes part in interrupt generation only while its status bit is 1 and its mask bit is 0. Software changes mask bits through per-bank write-one-to-set and write-one-to-clear strobes. These share one data word. There is no plain write of the mask.

A command port takes a packed 12-bit interrupt ID and either enables or disables one source. The bank is chosen by ORing two 3-bit fields of the ID. The block drives a registered combined request. It also drives the flat index of the source to service next. The search favours the highest bank first and then the lowest bit position within that bank.

Top module: `irq_bank_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, every mask bit is 1, status is all zero, `irq_o` is 0 and `next_valid_o` is 0.
- R2: `status_o` equals `src_i` as sampled at the previous rising clock edge, with no latching of past levels.
- R3: Pulsing bit b of `mask_set_we_i` sets, at the next edge, every bit of bank b's mask where `mask_wdata_i` is 1 and leaves the other bits unchanged. Bank b occupies `mask_o[32*b+31:32*b]`.
- R4: Pulsing bit b of `mask_clr_we_i` clears, at the next edge, every bit of bank b's mask where `mask_wdata_i` is 1 and leaves the other bits unchanged.
- R5: When a set and a clear reach the same mask bit in the same cycle, from any mix of bank strobes and commands, the bit ends up 1.
- R6: A command ID decodes as raw = `id[11:9] | id[7:5]` and bit = `id[4:0]`. A raw value of 0 selects bank 0, a raw value of 1 selects bank 1, and any raw value of 2 or more selects bank 2. The flat index is 32*bank + bit, and `id[8]` has no effect.
- R7: With `cmd_valid_i` high, `cmd_op_i`=1 (disable) sets the mask bit of the decoded source at the next edge, and `cmd_op_i`=0 (enable) clears it. With `cmd_valid_i` low the command has no effect.
- R8: `irq_o` is 1 exactly one cycle after any bit of `status_o & ~mask_o` was 1.
- R9: `next_valid_o` is 1 when any bit of `status_o & ~mask_o` is 1. `next_idx_o` then gives the flat index of the active bit in the highest bank that has one, and the lowest such bit within that bank. Both outputs follow the current status and mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Level interrupt sources, flat index order |
| mask_set_we_i | input | 3 | Per-bank write-one-to-set strobe |
| mask_clr_we_i | input | 3 | Per-bank write-one-to-clear strobe |
| mask_wdata_i | input | 32 | Data word shared by the mask strobes |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 1 | 1 disables the source, 0 enables it |
| cmd_id_i | input | 12 | Packed interrupt ID |
| status_o | output | 96 | Sampled source levels |
| mask_o | output | 96 | Current mask, 1 means disabled |
| irq_o | output | 1 | Registered combined request |
| next_valid_o | output | 1 | Some source is active |
| next_idx_o | output | 7 | Flat index of the source to service next |

## Verification
The assertions assume that every input has a known value on each rising edge after reset. They also assume that a command and a bank strobe can target the same bit in the same cycle, so they are phrased to allow set-over-clear overlap instead of ruling it out. The stimulus changes inputs only on the falling edge and drives only defined values. It combines random source words, random strobe patterns and random IDs, so every raw bank code and deliberate set/clear collisions occur during the run.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int NBANK  = 3;
  localparam int BANK_W = 32;
  localparam int ID_W   = 12;
  localparam int IDX_W  = $clog2(NBANK * BANK_W);

  typedef enum logic {
    OP_ENABLE  = 1'b0,
    OP_DISABLE = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int NBANK  = 3,
  parameter int BANK_W = 32,
  parameter int ID_W   = 12,
  localparam int BSEL_W = $clog2(NBANK),
  localparam int BIT_W  = $clog2(BANK_W),
  localparam int IDX_W  = $clog2(NBANK * BANK_W)
) (
  input  logic [ID_W-1:0]   id_i,
  output logic [BSEL_W-1:0] bank_o,
  output logic [IDX_W-1:0]  flat_o
);
  localparam int FLD_W  = 3;
  localparam int HI_LSB = 9;
  localparam int LO_LSB = 5;

  logic [FLD_W-1:0] raw;
  logic [BIT_W-1:0] bit_sel;
  logic             unused_gap;

  assign raw        = id_i[HI_LSB +: FLD_W] | id_i[LO_LSB +: FLD_W];
  assign bit_sel    = id_i[BIT_W-1:0];
  assign unused_gap = ^{id_i[HI_LSB-1:LO_LSB+FLD_W]};

  // raw values beyond the last bank saturate onto it
  always_comb begin
    if (int'(raw) >= NBANK - 1) bank_o = BSEL_W'(NBANK - 1);
    else                        bank_o = BSEL_W'(raw);
  end

  assign flat_o = IDX_W'(int'(bank_o) * BANK_W + int'(bit_sel));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] set_i,
  input  logic [BANK_W-1:0] clr_i,
  output logic [BANK_W-1:0] mask_o
);
  logic [BANK_W-1:0] mask_q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q & ~clr_i) | set_i;
  end

  assign mask_o = mask_q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((mask_q & $past(set_i)) == $past(set_i)));

  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((mask_q & $past(clr_i & ~set_i)) == '0));

  assert_untouched_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NBANK  = 3,
  parameter int BANK_W = 32,
  localparam int NSRC  = NBANK * BANK_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  active_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NBANK-1:0] hit;
  logic [IDX_W-1:0] pos [NBANK];

  // lowest set bit per bank
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      hit[b] = 1'b0;
      pos[b] = '0;
      for (int i = BANK_W - 1; i >= 0; i--) begin
        if (active_i[b*BANK_W + i]) begin
          hit[b] = 1'b1;
          pos[b] = IDX_W'(b * BANK_W + i);
        end
      end
    end
  end

  // higher bank overrides lower
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit[b]) begin
        valid_o = 1'b1;
        idx_o   = pos[b];
      end
    end
  end

  assert_pick_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> active_i[idx_o]);

  assert_none_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (active_i == '0));
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NB    = NBANK,
  parameter int BW    = BANK_W,
  parameter int IW    = ID_W,
  localparam int NSRC = NB * BW,
  localparam int XW   = $clog2(NSRC),
  localparam int SW   = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NB-1:0]   mask_set_we_i,
  input  logic [NB-1:0]   mask_clr_we_i,
  input  logic [BW-1:0]   mask_wdata_i,
  input  logic            cmd_valid_i,
  input  logic            cmd_op_i,
  input  logic [IW-1:0]   cmd_id_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o,
  output logic            next_valid_o,
  output logic [XW-1:0]   next_idx_o
);
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] active;
  logic            irq_q;
  logic [SW-1:0]   cmd_bank;
  logic [XW-1:0]   cmd_flat;
  logic            cmd_dis, cmd_en;

  irq_id_decode #(.NBANK(NB), .BANK_W(BW), .ID_W(IW)) u_dec (
    .id_i   (cmd_id_i),
    .bank_o (cmd_bank),
    .flat_o (cmd_flat)
  );

  assign cmd_dis = cmd_valid_i && (cmd_op_e'(cmd_op_i) == OP_DISABLE);
  assign cmd_en  = cmd_valid_i && (cmd_op_e'(cmd_op_i) == OP_ENABLE);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BW-1:0] set_v, clr_v, onehot;
    logic          sel;

    assign sel    = (int'(cmd_bank) == b);
    assign onehot = BW'(1) << (int'(cmd_flat) - b * BW);
    assign set_v  = (mask_set_we_i[b] ? mask_wdata_i : '0) | ((cmd_dis && sel) ? onehot : '0);
    assign clr_v  = (mask_clr_we_i[b] ? mask_wdata_i : '0) | ((cmd_en  && sel) ? onehot : '0);

    irq_mask_bank #(.BANK_W(BW)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .mask_o (mask_o[b*BW +: BW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= src_i;
      irq_q    <= |active;
    end
  end

  assign active   = status_q & ~mask_o;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  irq_prio_pick #(.NBANK(NB), .BANK_W(BW)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .valid_o  (next_valid_o),
    .idx_o    (next_idx_o)
  );

  assert_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o == $past(src_i)));

  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_valid_o |=> irq_o);

  assert_irq_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !next_valid_o |=> !irq_o);

  assert_cmd_dis_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_dis |=> mask_o[$past(cmd_flat)]);

  assert_cmd_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en && !mask_set_we_i[cmd_bank]) |=> !mask_o[$past(cmd_flat)]);
endmodule

// File: tb/irq_bank_ctrl_test.sv
module irq_bank_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] src_i = '0;
  logic [2:0]  mask_set_we_i = '0;
  logic [2:0]  mask_clr_we_i = '0;
  logic [31:0] mask_wdata_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_op_i = 1'b0;
  logic [11:0] cmd_id_i = '0;
  logic [95:0] status_o, mask_o;
  logic        irq_o, next_valid_o;
  logic [6:0]  next_idx_o;

  int total = 0;
  int bad = 0;
  string mtag = "R1";

  logic [95:0] m_status = '0;
  logic [95:0] m_mask = '1;
  logic        m_irq = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_bank_ctrl uut (.*);

  function automatic int exp_flat(logic [11:0] id);
    logic [2:0] raw;
    int bank;
    raw  = id[11:9] | id[7:5];
    bank = (raw == 3'd0) ? 0 : (raw == 3'd1) ? 1 : 2;
    return bank * 32 + int'(id[4:0]);
  endfunction

  function automatic logic [7:0] exp_pick(logic [95:0] act);
    for (int b = 2; b >= 0; b--)
      for (int i = 0; i < 32; i++)
        if (act[b*32 + i]) return {1'b1, 7'(b*32 + i)};
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] p;
    p = exp_pick(m_status & ~m_mask);
    chk("R2 status", status_o, m_status);
    chk({mtag, " mask"}, mask_o, m_mask);
    chk("R8 irq", 96'(irq_o), 96'(m_irq));
    chk("R9 next", 96'({next_valid_o, next_idx_o}), 96'(p));
  endtask

  task automatic tick();
    logic [95:0] s, c;
    @(posedge clk_i);
    s = '0; c = '0;
    for (int b = 0; b < 3; b++) begin
      if (mask_set_we_i[b]) s[b*32 +: 32] = mask_wdata_i;
      if (mask_clr_we_i[b]) c[b*32 +: 32] = mask_wdata_i;
    end
    if (cmd_valid_i) begin
      if (cmd_op_i) s[exp_flat(cmd_id_i)] = 1'b1;
      else          c[exp_flat(cmd_id_i)] = 1'b1;
    end
    m_irq    = |(m_status & ~m_mask);
    m_mask   = (m_mask & ~c) | s;
    m_status = src_i;
    @(negedge clk_i);
    check_all();
    mask_set_we_i = '0;
    mask_clr_we_i = '0;
    cmd_valid_i   = 1'b0;
  endtask

  task automatic cmd(logic op, logic [11:0] id, logic v = 1'b1);
    cmd_valid_i = v; cmd_op_i = op; cmd_id_i = id;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    mtag = "R1";
    check_all();
    rst_ni = 1'b1;
    src_i = {32'h1, 32'h1, 32'h1};
    tick(); // R1: masks stay set, nothing active
    tick();

    mtag = "R4";
    mask_wdata_i = '1; mask_clr_we_i = 3'b111;
    tick();
    mtag = "R3";
    mask_wdata_i = 32'h0000_F00F; mask_set_we_i = 3'b010;
    tick();
    mtag = "R5";
    mask_wdata_i = 32'h00FF_0000; mask_set_we_i = 3'b001; mask_clr_we_i = 3'b001;
    tick();

    // R9: bank1 bit0 masked, bank1 bit5 wins over bank0
    src_i = '0; src_i[3] = 1'b1; src_i[32] = 1'b1; src_i[37] = 1'b1;
    tick(); tick();
    src_i[95] = 1'b1; src_i[70] = 1'b1;
    tick(); tick();
    src_i = '0;
    tick(); tick();

    mtag = "R6";
    cmd(1'b1, {3'b000, 1'b0, 3'b001, 5'd5});
    cmd(1'b0, {3'b001, 1'b1, 3'b000, 5'd5});
    cmd(1'b1, {3'b010, 1'b0, 3'b001, 5'd7});
    cmd(1'b0, {3'b111, 1'b1, 3'b111, 5'd31});
    cmd(1'b1, {3'b000, 1'b1, 3'b000, 5'd0});
    mtag = "R7";
    cmd(1'b0, 12'h000, 1'b0);
    cmd(1'b1, {3'b000, 1'b0, 3'b000, 5'd20}, 1'b0);
    // R5: command enable colliding with bank set
    mtag = "R5";
    mask_wdata_i = 32'h0000_0100; mask_set_we_i = 3'b100;
    cmd(1'b0, {3'b100, 1'b0, 3'b000, 5'd8});

    mtag = "R7";
    for (int n = 0; n < 3000; n++) begin
      src_i = {$urandom() & $urandom(), $urandom() & $urandom(), $urandom() & $urandom()};
      mask_wdata_i  = $urandom();
      mask_set_we_i = ($urandom_range(0, 3) == 0) ? 3'($urandom()) : 3'b000;
      mask_clr_we_i = ($urandom_range(0, 2) == 0) ? 3'($urandom()) : 3'b000;
      cmd_valid_i   = 1'($urandom());
      cmd_op_i      = 1'($urandom());
      cmd_id_i      = 12'($urandom());
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule